// File: doc/BRIEF.md
# DMA Upper Address Extension Selector

This block builds the full 64-bit address and the 24-bit transfer length for one block move of a SCSI-style scripts controller. The move is described by a table-indirect descriptor. Its first 32-bit word carries the byte count in the low 24 bits and an extension field in the top byte. Its second word is the low 32 address bits. Mode bits in a chip-control byte decide how the extension field is read:

- **Wide (40-bit) mode:** the extension field is the address byte above bit 31.
- **Table-indirect 64-bit mode:** five bits of the field select the upper address word from a bank of scratch registers or from six named segment registers.
- **Neither mode:** a live fallback supplies the upper word.

A load strobe captures the decoded length, the low address and the chosen upper word into holding registers. These become visible one cycle later. When a selector names no register, the block raises a one-cycle error pulse, forces the captured upper word to zero and still captures the length.

The scratch bank and the segment registers are plain inputs owned by the surrounding controller. The block does no register decoding, memory fetch or data transfer.

Top module: `dma_hiaddr_sel`

## Requirements
- R1: On a cycle with `load_i` high, `byte_cnt_o` takes `desc_w0_i[23:0]` on the next cycle, whatever `desc_w0_i[31:24]` holds. `addr_o[31:0]` takes `desc_lo_i` on that same cycle.
- R2: Wide mode is active when `ctl_i[1]` and `ctl_i[2]` are both 1. A load in this mode captures `{24'b0, desc_w0_i[31:24]}` as the upper word `ext_hi_o`.
- R3: Table-indirect 64-bit mode is active when `ctl_i[1]` is 1 and `ctl_i[2]` is 0. The selector is `desc_w0_i[28:24]`. On a load, a selector from 0 to 15 captures scratch word `2 + selector`. Scratch word n sits at `scratch_i[32*n +: 32]`.
- R4: In table-indirect 64-bit mode, selectors 16 to 21 capture, in this order: `mm_rd_seg_i`, `mm_wr_seg_i`, `fetch_seg_i`, `dsa_rel_seg_i`, `stat_mv_seg_i`, `dyn_mv_seg_i`.
- R5: In table-indirect 64-bit mode, a load whose selector is 22 or higher has three effects on the next cycle: `ext_hi_o` is 0, `sel_err_o` is 1 for exactly that cycle, and the byte count is still captured as in R1. `sel_err_o` is 0 in every other case.
- R6: With `ctl_i[1]` at 0, a load captures 0 as `ext_hi_o`. `addr_o[63:32]` then follows the inputs combinationally: it is `dyn_mv_seg_i` if that is nonzero, otherwise `stat_mv_seg_i` if that is nonzero, otherwise 0.
- R7: While `ctl_i[1]` is 1, `addr_o[63:32]` equals the captured `ext_hi_o`, whatever the fallback inputs hold.
- R8: On a cycle with `load_i` low, `byte_cnt_o`, `ext_hi_o` and `addr_o[31:0]` keep their values, whatever the descriptor inputs do.
- R9: While `rst_n` is low, `byte_cnt_o`, `ext_hi_o`, `addr_o[31:0]` and `sel_err_o` are all 0.
- R10: `ctl_i[0]`, `ctl_i[3]` and `ctl_i[7:4]` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 8 | Chip-control byte; bits 1 and 2 choose the mode |
| load_i | input | 1 | Capture strobe for the descriptor |
| desc_w0_i | input | 32 | First descriptor word: extension byte and byte count |
| desc_lo_i | input | 32 | Second descriptor word: low address |
| scratch_i | input | 576 | Scratch bank, 18 words of 32 bits, word n at bits 32n+31:32n |
| mm_rd_seg_i | input | 32 | Memory-move read segment word (selector 16) |
| mm_wr_seg_i | input | 32 | Memory-move write segment word (selector 17) |
| fetch_seg_i | input | 32 | Script-fetch segment word (selector 18) |
| dsa_rel_seg_i | input | 32 | Data-structure-relative segment word (selector 19) |
| stat_mv_seg_i | input | 32 | Static block-move segment word (selector 20, second fallback) |
| dyn_mv_seg_i | input | 32 | Dynamic block-move segment word (selector 21, first fallback) |
| addr_o | output | 64 | Full DMA address |
| byte_cnt_o | output | 24 | Captured byte count |
| sel_err_o | output | 1 | One-cycle pulse after a load with an illegal selector |
| ext_hi_o | output | 32 | Captured upper address word |

## Verification
The hardest situation to reach is an illegal selector followed by a second illegal load, or by a legal one, on the very next cycle. Both must keep the error pulse tied to each load rather than to a level. The bench issues back-to-back loads with selector 22 and then 31, and follows at once with a legal selector. Every clock it compares against a model that tracks the expected pulse separately.

Two other cases need the mode inputs to change while no load is happening:
- The fallback priority is reached by changing the dynamic and static segment inputs between loads.
- The live switch between the captured word and the fallback is reached by flipping `ctl_i[1]` with no load.

// File: rtl/dxs_pkg.sv
package dxs_pkg;

  typedef enum logic [1:0] {
    XM_PLAIN = 2'd0,
    XM_TI64  = 2'd1,
    XM_WIDE  = 2'd2
  } xmode_e;

  localparam int CB_TI64 = 1;
  localparam int CB_VAR  = 2;
  localparam int CNT_W   = 24;
  localparam int SEL_LSB = 24;
  localparam int SEL_W   = 5;

  function automatic xmode_e mode_of(input logic ti64_bit, input logic var_bit);
    if (ti64_bit && var_bit) return XM_WIDE;
    if (ti64_bit)            return XM_TI64;
    return XM_PLAIN;
  endfunction

  function automatic logic [CNT_W-1:0] count_of(input logic [31:0] w0);
    return w0[CNT_W-1:0];
  endfunction

  function automatic logic [SEL_W-1:0] sel_of(input logic [31:0] w0);
    return w0[SEL_LSB +: SEL_W];
  endfunction

  function automatic logic [31:0] wide_hi_of(input logic [31:0] w0);
    return {24'h0, w0[31:24]};
  endfunction

  function automatic logic [31:0] fallback_hi(input logic [31:0] dyn_w,
                                              input logic [31:0] stat_w);
    if (dyn_w != 32'h0)  return dyn_w;
    if (stat_w != 32'h0) return stat_w;
    return 32'h0;
  endfunction

endpackage

// File: rtl/dxs_mode_dec.sv
module dxs_mode_dec
  import dxs_pkg::*;
(
  input  logic   ti64_bit_i,
  input  logic   var_bit_i,
  output xmode_e mode_o,
  output logic   ext_on_o
);

  assign mode_o   = mode_of(ti64_bit_i, var_bit_i);
  assign ext_on_o = (mode_o != XM_PLAIN);

endmodule

// File: rtl/dxs_sel_mux.sv
module dxs_sel_mux #(
  parameter int W        = 32,
  parameter int SCR_N    = 18,
  parameter int SCR_BASE = 2,
  parameter int NSCR_SEL = 16,
  parameter int NSEG     = 6,
  parameter int SEL_W    = 5
) (
  input  logic [SEL_W-1:0]    sel_i,
  input  logic [SCR_N*W-1:0]  scratch_i,
  input  logic [NSEG*W-1:0]   seg_i,
  output logic [W-1:0]        word_o,
  output logic                illegal_o
);

  localparam int TBL_N    = 1 << SEL_W;
  localparam int LAST_SEL = NSCR_SEL + NSEG - 1;

  logic [W-1:0] tbl   [TBL_N];
  logic         valid [TBL_N];

  for (genvar k = 0; k < TBL_N; k++) begin : g_ent
    if (k < NSCR_SEL && (SCR_BASE + k) < SCR_N) begin : g_scr
      assign tbl[k]   = scratch_i[(SCR_BASE + k)*W +: W];
      assign valid[k] = 1'b1;
    end else if (k >= NSCR_SEL && k <= LAST_SEL) begin : g_seg
      assign tbl[k]   = seg_i[(k - NSCR_SEL)*W +: W];
      assign valid[k] = 1'b1;
    end else begin : g_none
      assign tbl[k]   = '0;
      assign valid[k] = 1'b0;
    end
  end

  assign word_o    = valid[sel_i] ? tbl[sel_i] : '0;
  assign illegal_o = !valid[sel_i];

endmodule

// File: rtl/dxs_hold_regs.sv
module dxs_hold_regs #(
  parameter int W     = 32,
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [W-1:0]     lo_d,
  input  logic [W-1:0]     hi_d,
  input  logic [CNT_W-1:0] cnt_d,
  input  logic             bad_d,
  output logic [W-1:0]     lo_q,
  output logic [W-1:0]     hi_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             bad_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q  <= '0;
      hi_q  <= '0;
      cnt_q <= '0;
      bad_q <= 1'b0;
    end else begin
      bad_q <= load_i && bad_d;
      if (load_i) begin
        lo_q  <= lo_d;
        hi_q  <= hi_d;
        cnt_q <= cnt_d;
      end
    end
  end

endmodule

// File: rtl/dma_hiaddr_sel.sv
module dma_hiaddr_sel
  import dxs_pkg::*;
#(
  parameter int W        = 32,
  parameter int SCR_N    = 18,
  parameter int SCR_BASE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       ctl_i,
  input  logic             load_i,
  input  logic [31:0]      desc_w0_i,
  input  logic [W-1:0]     desc_lo_i,
  input  logic [SCR_N*W-1:0] scratch_i,
  input  logic [W-1:0]     mm_rd_seg_i,
  input  logic [W-1:0]     mm_wr_seg_i,
  input  logic [W-1:0]     fetch_seg_i,
  input  logic [W-1:0]     dsa_rel_seg_i,
  input  logic [W-1:0]     stat_mv_seg_i,
  input  logic [W-1:0]     dyn_mv_seg_i,
  output logic [2*W-1:0]   addr_o,
  output logic [CNT_W-1:0] byte_cnt_o,
  output logic             sel_err_o,
  output logic [W-1:0]     ext_hi_o
);

  localparam int NSEG = 6;

  // Control bits outside the mode pair play no part here.
  logic unused_ctl;
  assign unused_ctl = ^{ctl_i[7:3], ctl_i[0]};

  xmode_e mode;
  logic   ext_on;

  dxs_mode_dec u_dec (
    .ti64_bit_i (ctl_i[CB_TI64]),
    .var_bit_i  (ctl_i[CB_VAR]),
    .mode_o     (mode),
    .ext_on_o   (ext_on)
  );

  logic [SEL_W-1:0] sel;
  logic [W-1:0]     sel_word;
  logic             sel_illegal;
  logic [NSEG*W-1:0] seg_bus;

  assign sel     = sel_of(desc_w0_i);
  assign seg_bus = {dyn_mv_seg_i, stat_mv_seg_i, dsa_rel_seg_i,
                    fetch_seg_i, mm_wr_seg_i, mm_rd_seg_i};

  dxs_sel_mux #(
    .W        (W),
    .SCR_N    (SCR_N),
    .SCR_BASE (SCR_BASE),
    .NSCR_SEL (16),
    .NSEG     (NSEG),
    .SEL_W    (SEL_W)
  ) u_mux (
    .sel_i     (sel),
    .scratch_i (scratch_i),
    .seg_i     (seg_bus),
    .word_o    (sel_word),
    .illegal_o (sel_illegal)
  );

  // Named events for the checks below.
  logic         bad_evt;
  logic [W-1:0] hi_next;

  assign bad_evt = (mode == XM_TI64) && sel_illegal;

  always_comb begin
    unique case (mode)
      XM_WIDE: hi_next = wide_hi_of(desc_w0_i);
      XM_TI64: hi_next = sel_word;
      default: hi_next = '0;
    endcase
  end

  logic [W-1:0] lo_q;

  dxs_hold_regs #(.W(W), .CNT_W(CNT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (load_i),
    .lo_d   (desc_lo_i),
    .hi_d   (hi_next),
    .cnt_d  (count_of(desc_w0_i)),
    .bad_d  (bad_evt),
    .lo_q   (lo_q),
    .hi_q   (ext_hi_o),
    .cnt_q  (byte_cnt_o),
    .bad_q  (sel_err_o)
  );

  assign addr_o = {ext_on ? ext_hi_o : fallback_hi(dyn_mv_seg_i, stat_mv_seg_i), lo_q};

  AST_CNT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> byte_cnt_o == $past(desc_w0_i[23:0])); // R1

  AST_WIDE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && ctl_i[1] && ctl_i[2]) |=> ext_hi_o[31:8] == 24'h0); // R2

  AST_ERR_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |-> $past(load_i)); // R5

  AST_ERR_ZERO_HI: assert property (@(posedge clk) disable iff (!rst_n)
    sel_err_o |-> ext_hi_o == '0); // R5

  AST_HOLD_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> ($stable(ext_hi_o) && $stable(byte_cnt_o) && $stable(addr_o[W-1:0]))); // R8

  AST_PLAIN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !ctl_i[1]) |=> ext_hi_o == '0); // R6

endmodule

// File: tb/dma_hiaddr_sel_bench.sv
module dma_hiaddr_sel_bench;

  localparam int W = 32;
  localparam int SCR_N = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  ctl = 8'h00;
  logic        load = 1'b0;
  logic [31:0] w0 = 32'h0;
  logic [31:0] lo = 32'h0;
  logic [31:0] scr [SCR_N];
  logic [SCR_N*W-1:0] scr_flat;
  logic [31:0] seg [6];
  logic [63:0] addr;
  logic [23:0] cnt;
  logic        err;
  logic [31:0] ehi;

  always #4 clk = ~clk;

  always_comb
    for (int i = 0; i < SCR_N; i++) scr_flat[i*W +: W] = scr[i];

  dma_hiaddr_sel u_dma_hiaddr_sel (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .load_i(load),
    .desc_w0_i(w0), .desc_lo_i(lo), .scratch_i(scr_flat),
    .mm_rd_seg_i(seg[0]), .mm_wr_seg_i(seg[1]), .fetch_seg_i(seg[2]),
    .dsa_rel_seg_i(seg[3]), .stat_mv_seg_i(seg[4]), .dyn_mv_seg_i(seg[5]),
    .addr_o(addr), .byte_cnt_o(cnt), .sel_err_o(err), .ext_hi_o(ehi)
  );

  int errors = 0;
  int checks = 0;
  string cur_req = "R9";
  bit cmp_on = 1'b0;

  // Behavioural reference model
  logic [31:0] m_lo, m_hi;
  logic [23:0] m_cnt;
  logic        m_err;

  function automatic logic [31:0] ref_upper(input logic [7:0] c, input logic [31:0] d,
                                            output logic bad);
    int s;
    s = (d >> 24) % 32;
    bad = 1'b0;
    if (c[1] == 1'b0) return 32'h0;
    if (c[2] == 1'b1) return d >> 24;
    if (s < 16) return scr[s + 2];
    if (s < 22) return seg[s - 16];
    bad = 1'b1;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_lo <= 0; m_hi <= 0; m_cnt <= 0; m_err <= 0;
    end else begin
      logic b;
      logic [31:0] h;
      h = ref_upper(ctl, w0, b);
      m_err <= load && b;
      if (load) begin
        m_lo  <= lo;
        m_hi  <= h;
        m_cnt <= w0 % 32'h0100_0000;
      end
    end
  end

  task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (cmp_on) begin
    logic [31:0] top;
    if (ctl[1]) top = m_hi;
    else if (seg[5] != 0) top = seg[5];
    else if (seg[4] != 0) top = seg[4];
    else top = 0;
    chk("count", {40'h0, cnt}, {40'h0, m_cnt});
    chk("ext_hi", {32'h0, ehi}, {32'h0, m_hi});
    chk("addr", addr, {top, m_lo});
    chk("sel_err", {63'h0, err}, {63'h0, m_err});
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic ld(input logic [7:0] c, input logic [31:0] d, input logic [31:0] l);
    ctl = c; w0 = d; lo = l; load = 1'b1;
    step(1);
    load = 1'b0;
  endtask

  initial begin
    #1600000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < SCR_N; i++) scr[i] = 32'hA000_0000 + i * 32'h111;
    seg[0] = 32'h1111_0001; seg[1] = 32'h2222_0002; seg[2] = 32'h3333_0003;
    seg[3] = 32'h4444_0004; seg[4] = 32'h0;         seg[5] = 32'h0;
    w0 = 32'hFFFF_FFFF; lo = 32'hDEAD_BEEF; ctl = 8'h06;
    step(2);
    @(negedge clk);
    cur_req = "R9";
    chk("reset count", {40'h0, cnt}, 64'h0);
    chk("reset ext_hi", {32'h0, ehi}, 64'h0);
    chk("reset addr", addr, {32'h0, 32'h0});
    chk("reset err", {63'h0, err}, 64'h0);
    rst_n = 1'b1;
    step(1);
    cmp_on = 1'b1;

    cur_req = "R1";
    ld(8'h00, 32'hAB12_3456, 32'h1000_0000);
    ld(8'h00, 32'hFF00_0000, 32'h1000_0004);
    ld(8'h00, 32'h00FF_FFFF, 32'hFFFF_FFFC);
    step(2);

    cur_req = "R6";
    seg[4] = 32'h5555_0005; step(2);
    seg[5] = 32'h6666_0006; step(2);
    seg[4] = 32'h0;         step(2);
    seg[5] = 32'h0;         step(2);
    seg[4] = 32'h5555_0005; seg[5] = 32'h6666_0006;
    ld(8'h00, 32'h1500_0010, 32'h2000_0000);
    step(1);

    cur_req = "R2";
    ld(8'h06, 32'hFF00_0100, 32'h3000_0000);
    ld(8'h06, 32'h5A00_0200, 32'h3000_0100);
    ld(8'h06, 32'h1F00_0300, 32'h3000_0200);
    step(1);

    cur_req = "R3";
    for (int s = 0; s < 16; s++) ld(8'h02, {3'b000, 5'(s), 24'h400 + 24'(s)}, 32'h4000_0000 + s);
    step(1);

    cur_req = "R4";
    for (int s = 16; s < 22; s++) ld(8'h02, {3'b111, 5'(s), 24'h500 + 24'(s)}, 32'h5000_0000 + s);
    step(1);

    cur_req = "R5";
    ld(8'h02, {8'h16, 24'h00_0777}, 32'h6000_0000);
    step(2);
    ld(8'h02, {8'h16, 24'h00_0888}, 32'h6000_0010);
    ld(8'h02, {8'h1F, 24'h00_0999}, 32'h6000_0020);
    ld(8'h02, {8'h15, 24'h00_0AAA}, 32'h6000_0030);
    ld(8'h02, {8'h17, 24'hFF_FFFF}, 32'h6000_0040);
    ld(8'h02, {8'h03, 24'h00_0001}, 32'h6000_0050);
    ld(8'h06, {8'h1F, 24'h00_0002}, 32'h6000_0060);
    step(2);

    cur_req = "R7";
    ld(8'h02, {8'h05, 24'h00_0123}, 32'h7000_0000);
    seg[5] = 32'h7777_0007; step(2);
    seg[4] = 32'h0; seg[5] = 32'h0; step(2);
    ctl = 8'h00; step(2);
    seg[4] = 32'h5555_0005; step(1);
    ctl = 8'h02; step(2);

    cur_req = "R8";
    w0 = 32'h1234_5678; lo = 32'h8888_0000; ctl = 8'h06; step(3);
    w0 = 32'h0A00_0001; ctl = 8'h02; step(3);

    cur_req = "R10";
    ld(8'hFB, {8'h07, 24'h00_0C01}, 32'h9000_0000);
    ld(8'hF9, {8'h07, 24'h00_0C02}, 32'h9000_0010);
    ld(8'h8F, {8'hAB, 24'h00_0C03}, 32'h9000_0020);
    ld(8'h79, {8'h11, 24'h00_0C04}, 32'h9000_0030);
    ld(8'hFD, {8'h13, 24'h00_0C05}, 32'h9000_0040);
    step(3);

    cmp_on = 1'b0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule